// File: doc/BRIEF.md
# Phase Counting Decoder

This block turns external phase signals into count events for a downstream up/down counter. Each of four asynchronous phase inputs passes through a synchroniser. The current and previous synchronised samples are then compared to find edges. A 4-bit mode code per channel chooses how a phase pair is read: full-resolution quadrature, pulse plus direction level, or half-resolution quadrature driven only by the second phase. Any other mode code is silent.

Two channels are built. Channel 0 always reads inputs A/B. Channel 1 reads A/B or C/D, chosen by a pair-select bit. On each qualifying sample a channel raises a one-cycle count strobe together with an up flag. It also keeps a status byte whose top bit records the direction of its latest event, for software to read.

Top module: `phase_count_decoder`

## Requirements
- R1: While reset is asserted and right after it is released, every strobe and up output is 0 and both status bytes read 0x00.
- R2: With mode code 4, every change of exactly one phase in the pair produces one count. The count is up when the pair steps forward through the order 00→10→11→01→00, written as (A,B), so that the first phase leads. Otherwise it is down.
- R3: With mode code 5, only a rising edge of the first phase counts. The second phase's level in that same sample gives the direction (1 = up). Falling edges of the first phase and any change of the second phase produce nothing.
- R4: With mode code 7, a change of the second phase while the first phase holds produces one count, with the same direction rule as R2. A change of the first phase alone never counts.
- R5: Mode codes other than 4, 5 and 7 (including 6 and 9) produce no count events, whatever the inputs do.
- R6: Channel 0 always decodes inputs A/B. Channel 1 decodes A/B when the pair-select bit is 0 and C/D when it is 1.
- R7: In the sample in which the pair-select bit changes, channel 1 makes no count, even when the old pair and the new pair differ.
- R8: In modes 4 and 7, a sample in which both phases of the pair changed together is ignored and produces no count.
- R9: A count strobe is high for exactly one clock per qualifying sample. It is registered and appears after the third rising clock edge that follows the input change. The up output is 1 only together with a strobe whose direction is up.
- R10: Bit 7 of a channel's status byte is 1 when that channel's most recent count was up and 0 when it was down. It holds between events, and all other bits of the byte read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ch_mode_i | input | 8 | Mode codes; bits 3:0 for channel 0, bits 7:4 for channel 1 |
| pair_sel_i | input | 1 | Channel 1 input pair: 0 = A/B, 1 = C/D |
| ph_a_i | input | 1 | External phase A (asynchronous) |
| ph_b_i | input | 1 | External phase B (asynchronous) |
| ph_c_i | input | 1 | External phase C (asynchronous) |
| ph_d_i | input | 1 | External phase D (asynchronous) |
| cnt_stb_o | output | 2 | One-cycle count strobe per channel |
| cnt_up_o | output | 2 | Up direction per channel, valid with the strobe |
| dir_stat_o | output | 16 | Status byte per channel; bits 7:0 channel 0, bits 15:8 channel 1 |

## Verification
Counts and status appear after the third rising edge that follows a phase change: two synchroniser flops, then the output register. The mode and pair-select inputs act at the very next edge, because they feed the output register directly. The reference model keeps a history of the inputs sampled at each rising edge and derives its expected outputs from the sample taken two edges earlier and the one before it. Every output is compared at the falling edge, half a period after it settles. Directed checks add event tallies against hand-counted totals, and a latency probe looks at each falling edge after a single phase change.

// File: rtl/pcd_pkg.sv
package pcd_pkg;
   localparam int MODE_W = 4;
   localparam int NCH    = 2;

   localparam logic [MODE_W-1:0] MODE_QUAD4 = 4'd4;
   localparam logic [MODE_W-1:0] MODE_PDIR  = 4'd5;
   localparam logic [MODE_W-1:0] MODE_HALFB = 4'd7;

   typedef struct packed {
      logic a;
      logic b;
   } phase_pair_t;

   function automatic logic mode_known(input logic [MODE_W-1:0] m);
      return (m == MODE_QUAD4) || (m == MODE_PDIR) || (m == MODE_HALFB);
   endfunction
endpackage

// File: rtl/pcd_sync.sv
module pcd_sync #(
   parameter int W      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pcd_sync needs at least two stages");
   end
   if (W < 1) begin : g_bad_width
      $error("pcd_sync width must be positive");
   end

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      end else begin
         stg[0] <= d_i;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q_o = stg[STAGES-1];
endmodule

// File: rtl/pcd_chan.sv
module pcd_chan
   import pcd_pkg::*;
#(
   parameter int STAT_W  = 8,
   parameter int DIR_BIT = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [MODE_W-1:0] mode_i,
   input  phase_pair_t       cur_i,
   input  logic              hold_i,
   output logic              stb_o,
   output logic              up_o,
   output logic [STAT_W-1:0] stat_o
);
   if (DIR_BIT >= STAT_W) begin : g_bad_dir_bit
      $error("pcd_chan direction bit outside status byte");
   end

   phase_pair_t prev_q;
   logic        dir_q;
   logic        a_chg, b_chg, quad_up;
   logic        ev, ev_dir, fire;

   assign a_chg   = cur_i.a ^ prev_q.a;
   assign b_chg   = cur_i.b ^ prev_q.b;
   assign quad_up = cur_i.a ^ prev_q.b;

   always_comb begin
      ev     = 1'b0;
      ev_dir = 1'b0;
      case (mode_i)
         MODE_QUAD4: begin
            ev     = a_chg ^ b_chg;
            ev_dir = quad_up;
         end
         MODE_PDIR: begin
            ev     = cur_i.a & ~prev_q.a;
            ev_dir = cur_i.b;
         end
         MODE_HALFB: begin
            ev     = b_chg & ~a_chg;
            ev_dir = quad_up;
         end
         default: begin
            ev     = 1'b0;
            ev_dir = 1'b0;
         end
      endcase
   end

   assign fire = ev & ~hold_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         stb_o  <= 1'b0;
         up_o   <= 1'b0;
         dir_q  <= 1'b0;
      end else begin
         prev_q <= cur_i;
         stb_o  <= fire;
         up_o   <= fire & ev_dir;
         if (fire) dir_q <= ev_dir;
      end
   end

   always_comb begin
      stat_o          = '0;
      stat_o[DIR_BIT] = dir_q;
   end

   a_r5_unknown_mode_silent: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_known(mode_i) |=> !stb_o);
   a_r4_a_alone_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == MODE_HALFB && a_chg && !b_chg) |=> !stb_o);
   a_r8_double_step_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode_i == MODE_QUAD4 || mode_i == MODE_HALFB) && a_chg && b_chg) |=> !stb_o);
   a_r9_up_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      up_o |-> (stb_o && stat_o[DIR_BIT]));
   a_r10_status_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !stb_o |-> $stable(stat_o));
endmodule

// File: rtl/phase_count_decoder.sv
module phase_count_decoder
   import pcd_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int STAT_W      = 8,
   parameter int DIR_BIT     = 7
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NCH*MODE_W-1:0] ch_mode_i,
   input  logic                  pair_sel_i,
   input  logic                  ph_a_i,
   input  logic                  ph_b_i,
   input  logic                  ph_c_i,
   input  logic                  ph_d_i,
   output logic [NCH-1:0]        cnt_stb_o,
   output logic [NCH-1:0]        cnt_up_o,
   output logic [NCH*STAT_W-1:0] dir_stat_o
);
   localparam int NPH = 4;

   logic [NPH-1:0] raw_ph, syn_ph;
   logic           sel_q;

   assign raw_ph = {ph_a_i, ph_b_i, ph_c_i, ph_d_i};

   pcd_sync #(.W(NPH), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (raw_ph),
      .q_o   (syn_ph)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sel_q <= 1'b0;
      else        sel_q <= pair_sel_i;
   end

   for (genvar g = 0; g < NCH; g++) begin : g_ch
      phase_pair_t pair;
      logic        hold;

      if (g == 0) begin : g_fixed
         assign pair.a = syn_ph[3];
         assign pair.b = syn_ph[2];
         assign hold   = 1'b0;
      end else begin : g_muxed
         assign pair.a = pair_sel_i ? syn_ph[1] : syn_ph[3];
         assign pair.b = pair_sel_i ? syn_ph[0] : syn_ph[2];
         assign hold   = pair_sel_i ^ sel_q;
      end

      pcd_chan #(.STAT_W(STAT_W), .DIR_BIT(DIR_BIT)) u_chan (
         .clk    (clk),
         .rst_n  (rst_n),
         .mode_i (ch_mode_i[g*MODE_W +: MODE_W]),
         .cur_i  (pair),
         .hold_i (hold),
         .stb_o  (cnt_stb_o[g]),
         .up_o   (cnt_up_o[g]),
         .stat_o (dir_stat_o[g*STAT_W +: STAT_W])
      );
   end

   a_r7_switch_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (pair_sel_i != $past(pair_sel_i)) |=> !cnt_stb_o[1]);
endmodule

// File: tb/phase_count_decoder_bench.sv
module phase_count_decoder_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] mode = 8'h00;
   logic       sel = 1'b0;
   logic       a = 1'b0, b = 1'b0, c = 1'b0, d = 1'b0;
   logic [1:0]  stb, up;
   logic [15:0] stat;

   int total = 0;
   int bad   = 0;
   int tu [2];
   int td [2];

   always #2.5 clk = ~clk;

   phase_count_decoder u_phase_count_decoder (
      .clk(clk), .rst_n(rst_n), .ch_mode_i(mode), .pair_sel_i(sel),
      .ph_a_i(a), .ph_b_i(b), .ph_c_i(c), .ph_d_i(d),
      .cnt_stb_o(stb), .cnt_up_o(up), .dir_stat_o(stat)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // ---------------- reference model ----------------
   logic [3:0] hist [4];
   logic       last_sel;
   bit         e_stb [2];
   bit         e_up  [2];
   bit         e_dir [2];

   function automatic int gpos(input logic pa, input logic pb);
      case ({pa, pb})
         2'b00:   return 0;
         2'b10:   return 1;
         2'b11:   return 2;
         default: return 3;
      endcase
   endfunction

   function automatic void ref_dec(input logic [3:0] m, input logic ca, input logic cb,
                                   input logic pa, input logic pb,
                                   output bit ev, output bit dn_up);
      int step;
      ev = 0; dn_up = 0;
      step = (gpos(ca, cb) - gpos(pa, pb) + 4) % 4;
      if (m == 4'd4 && ((ca != pa) != (cb != pb))) begin ev = 1; dn_up = (step == 1); end
      else if (m == 4'd5 && ca && !pa)             begin ev = 1; dn_up = cb; end
      else if (m == 4'd7 && cb != pb && ca == pa)  begin ev = 1; dn_up = (step == 1); end
   endfunction

   function automatic string mode_tag(input logic [3:0] m);
      case (m)
         4'd4:    return "R2";
         4'd5:    return "R3";
         4'd7:    return "R4";
         default: return "R5";
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 4; i++) hist[i] = 4'b0;
         last_sel = 1'b0;
         for (int ch = 0; ch < 2; ch++) begin e_stb[ch] = 0; e_up[ch] = 0; e_dir[ch] = 0; end
      end else begin
         hist[3] = hist[2]; hist[2] = hist[1]; hist[1] = hist[0];
         hist[0] = {a, b, c, d};
         for (int ch = 0; ch < 2; ch++) begin
            logic ca, cb, pa, pb;
            bit ev, du, hold;
            ca = (ch == 1 && sel)      ? hist[2][1] : hist[2][3];
            cb = (ch == 1 && sel)      ? hist[2][0] : hist[2][2];
            pa = (ch == 1 && last_sel) ? hist[3][1] : hist[3][3];
            pb = (ch == 1 && last_sel) ? hist[3][0] : hist[3][2];
            hold = (ch == 1) && (sel != last_sel);
            ref_dec(mode[ch*4 +: 4], ca, cb, pa, pb, ev, du);
            e_stb[ch] = ev && !hold;
            e_up[ch]  = ev && !hold && du;
            if (ev && !hold) e_dir[ch] = du;
         end
         last_sel = sel;
      end
   end

   // cycle compare and tallies at the falling edge
   always @(negedge clk) begin
      if (rst_n) begin
         for (int ch = 0; ch < 2; ch++) begin
            chk(stb[ch] == e_stb[ch], mode_tag(mode[ch*4 +: 4]), stb[ch], e_stb[ch]);
            chk(up[ch] == e_up[ch], "R9", up[ch], e_up[ch]);
            chk(stat[ch*8 +: 8] == {e_dir[ch], 7'b0}, "R10", stat[ch*8 +: 8], {e_dir[ch], 7'b0});
            if (stb[ch]) begin
               if (up[ch]) tu[ch]++;
               else        td[ch]++;
            end
         end
      end
   end

   // ---------------- directed stimulus ----------------
   task automatic drv(input logic na, input logic nb, input logic nc, input logic nd);
      @(negedge clk);
      a = na; b = nb; c = nc; d = nd;
   endtask

   task automatic settle();
      repeat (5) @(negedge clk);
   endtask

   task automatic clr();
      @(posedge clk);
      tu[0] = 0; tu[1] = 0; td[0] = 0; td[1] = 0;
   endtask

   task automatic tally(input string req, input int ch, input int eu, input int ed);
      @(posedge clk);
      chk(tu[ch] == eu, req, tu[ch], eu);
      chk(td[ch] == ed, req, td[ch], ed);
   endtask

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog expired actual=1 expected=0");
      summary();
   end

   initial begin
      tu[0] = 0; tu[1] = 0; td[0] = 0; td[1] = 0;
      repeat (3) @(negedge clk);
      chk(stb == 2'b00 && up == 2'b00, "R1", {stb, up}, 0);
      chk(stat == 16'h0000, "R1", stat, 0);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      chk(stb == 2'b00 && stat == 16'h0000, "R1", stat, 0);

      // R2 + R6: x4 forward and reverse, both channels on A/B
      mode = 8'h44; clr();
      drv(1,0,0,0); drv(1,1,0,0); drv(0,1,0,0); drv(0,0,0,0);
      drv(1,0,0,0); drv(1,1,0,0); drv(0,1,0,0); drv(0,0,0,0);
      settle();
      tally("R2", 0, 8, 0); tally("R6", 1, 8, 0);
      clr();
      drv(0,1,0,0); drv(1,1,0,0); drv(1,0,0,0); drv(0,0,0,0);
      settle();
      tally("R2", 0, 0, 4);
      chk(stat[7:0] == 8'h00, "R10", stat[7:0], 0);

      // R9: latency and width of one strobe
      drv(1,0,0,0);
      @(negedge clk); chk(stb[0] == 1'b0, "R9", stb[0], 0);
      @(negedge clk); chk(stb[0] == 1'b0, "R9", stb[0], 0);
      @(negedge clk); chk(stb[0] == 1'b1 && up[0] == 1'b1, "R9", {stb[0], up[0]}, 3);
      @(negedge clk); chk(stb[0] == 1'b0, "R9", stb[0], 0);
      chk(stat[7:0] == 8'h80, "R10", stat[7:0], 8'h80);

      // R8: double transitions in x4 then x2-B
      drv(0,0,0,0); settle(); clr();
      drv(1,1,0,0); settle();
      mode = 8'h77;
      drv(0,0,0,0); settle();
      tally("R8", 0, 0, 0);

      // R3: pulse/direction
      mode = 8'h55; clr();
      drv(0,1,0,0);
      repeat (3) begin drv(1,1,0,0); drv(0,1,0,0); end
      drv(0,0,0,0);
      repeat (2) begin drv(1,0,0,0); drv(0,0,0,0); end
      drv(0,1,0,0); drv(0,0,0,0);
      settle();
      tally("R3", 0, 3, 2);
      chk(stat[7:0] == 8'h00, "R10", stat[7:0], 0);

      // R4: x2 on B only
      mode = 8'h77; clr();
      repeat (4) drv(~a, 0, 0, 0);
      settle();
      tally("R4", 0, 0, 0);
      drv(0,0,0,0); settle(); clr();
      repeat (2) begin drv(1,0,0,0); drv(1,1,0,0); drv(0,1,0,0); drv(0,0,0,0); end
      settle();
      tally("R4", 0, 4, 0);

      // R5: unsupported codes
      foreach (mode[i]) ;
      mode = 8'h96; clr();
      drv(1,0,1,0); drv(1,1,1,1); drv(0,1,0,1); drv(0,0,0,0);
      mode = 8'hF0;
      drv(1,0,1,0); drv(1,1,1,1); drv(0,1,0,1); drv(0,0,0,0);
      settle();
      tally("R5", 0, 0, 0); tally("R5", 1, 0, 0);

      // R6: channel 1 on C/D
      mode = 8'h44; sel = 1'b1; settle(); clr();
      drv(0,0,1,0); drv(0,0,1,1); drv(0,0,0,1); drv(0,0,0,0);
      settle();
      tally("R6", 1, 4, 0); tally("R6", 0, 0, 0);
      clr();
      drv(1,0,0,0); drv(1,1,0,0); drv(0,1,0,0); drv(0,0,0,0);
      settle();
      tally("R6", 0, 4, 0); tally("R6", 1, 0, 0);

      // R7: switching pairs with differing levels
      drv(0,0,1,0); settle(); clr();
      @(negedge clk); sel = 1'b0;
      settle();
      tally("R7", 1, 0, 0);
      @(negedge clk); sel = 1'b1;
      settle();
      tally("R7", 1, 0, 0);

      settle();
      summary();
   end
endmodule